// File: doc/BRIEF.md
# Write Strobe Qualifier with Reset Abort

This block stands between the asynchronous control pins of a parallel flash-style memory and its internal program/erase engine. It samples chip enable, output enable, write enable, an external device reset and a digital low-supply flag on a fast internal clock. A write is accepted only when the strobe has been held for at least a minimum number of clock cycles while every protection condition allows it. Each accepted write produces a single one-cycle commit pulse toward the engine.

The block also owns the reaction to the external device reset. While that reset is low, the block reports a halt and forces the data output enable off. If the reset falls while the engine reports it is busy, the block pulses an abort toward the engine. It then holds a failure flag until a later write is committed, so the host knows the interrupted operation must be issued again. When the device reset returns high, the data output enable follows the control pins again, giving read or standby.

Top module: `wiq_qualifier`

## Requirements
- R1: A write strobe is the condition `ce_n` = 0, `we_n` = 0 and `oe_n` = 1. If it is held for at least `MIN_W` consecutive clock cycles, `wr_commit` goes high for exactly one clock cycle.
- R2: A write strobe held for fewer than `MIN_W` consecutive cycles produces no `wr_commit`.
- R3: While `oe_n` = 0, no write strobe of any length produces `wr_commit`.
- R4: While `vlow` = 1, no write strobe of any length produces `wr_commit`.
- R5: While `dev_rst_n` = 0, `halt` is 1, `dq_oe` is 0 and no write strobe produces `wr_commit`.
- R6: When `dev_rst_n` falls while `busy` = 1, `abort` goes high for exactly one cycle. When it falls while `busy` = 0, `abort` stays low.
- R7: `op_failed` is set by every `abort` and stays set until the next `wr_commit`, which clears it in the same cycle that the pulse appears.
- R8: `dq_oe` is 1 only when `dev_rst_n` = 1, `ce_n` = 0, `oe_n` = 0 and `we_n` = 1. Any change on these inputs shows on `dq_oe` two clock cycles later.
- R9: If `dev_rst_n` falls in the same cycle in which a strobe would reach `MIN_W` cycles, the write is dropped and only `abort` is reported. If it falls one cycle later, the commit is followed by the abort.
- R10: After `dev_rst_n` returns high, `halt` clears, `dq_oe` follows the control pins again and a new strobe commits normally.
- R11: After system reset, `wr_commit`, `abort`, `op_failed`, `halt` and `dq_oe` are all 0 while the control inputs are idle.
- R12: A single strobe held far longer than `MIN_W` produces exactly one `wr_commit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | System reset, active low, asserted asynchronously |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| dev_rst_n | input | 1 | Device reset pin, active low, asynchronous |
| vlow | input | 1 | Supply-below-threshold flag, asynchronous |
| busy | input | 1 | Program/erase engine is running (synchronous) |
| wr_commit | output | 1 | One-cycle pulse: write accepted |
| abort | output | 1 | One-cycle pulse: running operation interrupted |
| op_failed | output | 1 | Last operation was aborted and must be reissued |
| halt | output | 1 | Device reset is active |
| dq_oe | output | 1 | Enable for the data output drivers |

## Verification
The commit path and the abort path can meet in one cycle. This happens when the device reset falls just as a write strobe completes its minimum width. The bench keeps `busy` high, starts a strobe and drops `dev_rst_n` exactly in the strobe's `MIN_W`-th cycle. The scoreboard must then see a lone abort and a set `op_failed`. A second run drops the reset one cycle later, and the scoreboard expects the commit followed by the abort, in that order.

// File: rtl/wiq_pkg.sv
package wiq_pkg;
  // Bit positions of the sampled control vector
  localparam int CTL_W  = 5;
  localparam int B_CE   = 0;
  localparam int B_OE   = 1;
  localparam int B_WE   = 2;
  localparam int B_RST  = 3;
  localparam int B_VLOW = 4;
  // Idle pin levels: strobes inactive, device reset released, supply good
  localparam logic [CTL_W-1:0] CTL_IDLE = 5'b01111;
endpackage

// File: rtl/wiq_rst_sync.sv
module wiq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/wiq_sync.sv
module wiq_sync #(
  parameter int              WIDTH   = 5,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[CHAIN_W-WIDTH-1:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/wiq_strobe_filter.sv
module wiq_strobe_filter #(
  parameter int MIN_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,     // qualified write condition, already synchronized
  output logic qualify,   // combinational: this cycle completes the minimum width
  output logic commit     // registered one-cycle pulse
);
  localparam int CNT_W = (MIN_W < 2) ? 1 : $clog2(MIN_W + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             commit_q;
  logic             commit_d;

  // Next-state logic
  always_comb begin
    cnt_en   = allow | (cnt_q != '0);
    cnt_d    = cnt_q;
    if (!allow)                cnt_d = '0;
    else if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    commit_d = allow & (cnt_q == CNT_LAST);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      commit_q <= commit_d;
    end
  end

  assign qualify = commit_d;
  assign commit  = commit_q;
endmodule

// File: rtl/wiq_reset_ctl.sv
module wiq_reset_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_rst_s,   // synchronized device reset, active low
  input  logic busy,
  input  logic qualify,     // a write is being accepted this cycle
  output logic abort,
  output logic op_failed,
  output logic halt
);
  logic rst_prev_q;
  logic abort_q;
  logic abort_d;
  logic fail_q;
  logic fail_d;
  logic fail_en;

  // Next-state logic
  always_comb begin
    abort_d = rst_prev_q & ~dev_rst_s & busy;
    fail_en = abort_d | qualify;
    fail_d  = abort_d;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_prev_q <= 1'b1;
      abort_q    <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      rst_prev_q <= dev_rst_s;
      abort_q    <= abort_d;
      if (fail_en) fail_q <= fail_d;
    end
  end

  assign abort     = abort_q;
  assign op_failed = fail_q;
  assign halt      = ~dev_rst_s;
endmodule

// File: rtl/wiq_qualifier.sv
module wiq_qualifier #(
  parameter int MIN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic dev_rst_n,
  input  logic vlow,
  input  logic busy,
  output logic wr_commit,
  output logic abort,
  output logic op_failed,
  output logic halt,
  output logic dq_oe
);
  import wiq_pkg::*;

  logic             rst_s_n;
  logic [CTL_W-1:0] pins;
  logic [CTL_W-1:0] pins_s;
  logic             strobe_on;
  logic             permit;
  logic             allow;
  logic             qualify;

  assign pins[B_CE]   = ce_n;
  assign pins[B_OE]   = oe_n;
  assign pins[B_WE]   = we_n;
  assign pins[B_RST]  = dev_rst_n;
  assign pins[B_VLOW] = vlow;

  wiq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  wiq_sync #(
    .WIDTH   (CTL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTL_IDLE)
  ) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     (pins),
    .q     (pins_s)
  );

  // Write strobe and protection conditions
  assign strobe_on = ~pins_s[B_CE] & ~pins_s[B_WE];
  assign permit    = pins_s[B_OE] & ~pins_s[B_VLOW] & pins_s[B_RST];
  assign allow     = strobe_on & permit;

  wiq_strobe_filter #(.MIN_W(MIN_W)) u_filter (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .allow   (allow),
    .qualify (qualify),
    .commit  (wr_commit)
  );

  wiq_reset_ctl u_reset_ctl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .dev_rst_s (pins_s[B_RST]),
    .busy      (busy),
    .qualify   (qualify),
    .abort     (abort),
    .op_failed (op_failed),
    .halt      (halt)
  );

  // Data output gating: read only while out of device reset and not writing
  assign dq_oe = pins_s[B_RST] & ~pins_s[B_CE] & ~pins_s[B_OE] & pins_s[B_WE];
endmodule

// File: rtl/wiq_qualifier_chk.sv
module wiq_qualifier_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic wr_commit,
  input logic abort,
  input logic op_failed
);
  // R1
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  // R6
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  // R6
  abort_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(busy));

  // R7
  abort_sets_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> op_failed);

  // R7
  commit_clears_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !op_failed);

  // R9
  abort_excludes_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !wr_commit);
endmodule

bind wiq_qualifier wiq_qualifier_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .wr_commit (wr_commit),
  .abort     (abort),
  .op_failed (op_failed)
);

// File: tb/wiq_qualifier_test.sv
module wiq_qualifier_test;
  localparam int MIN_W = 4;
  localparam int K_COMMIT = 1;
  localparam int K_ABORT  = 2;

  logic clk;
  logic rst_n;
  logic ce_n, oe_n, we_n, dev_rst_n, vlow, busy;
  logic wr_commit, abort, op_failed, halt, dq_oe;

  int    n_chk;
  int    n_fail;
  string cur_tag;
  int    kind_q[$];
  string tag_q[$];

  wiq_qualifier #(.MIN_W(MIN_W), .SYNC_STAGES(2)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .dev_rst_n (dev_rst_n),
    .vlow      (vlow),
    .busy      (busy),
    .wr_commit (wr_commit),
    .abort     (abort),
    .op_failed (op_failed),
    .halt      (halt),
    .dq_oe     (dq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input string tag);
    kind_q.push_back(kind);
    tag_q.push_back(tag);
  endtask

  task automatic take(input int kind);
    int    ek;
    string et;
    n_chk++;
    if (kind_q.size() == 0) begin
      n_fail++;
      $display("FAIL %s event: got kind %0d expected none", cur_tag, kind);
    end else begin
      ek = kind_q.pop_front();
      et = tag_q.pop_front();
      if (ek != kind) begin
        n_fail++;
        $display("FAIL %s event: got kind %0d expected kind %0d", et, kind, ek);
      end
    end
  endtask

  task automatic drain(input string tag);
    n_chk++;
    if (kind_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s missing events: got 0 expected %0d more", tag, kind_q.size());
      kind_q.delete();
      tag_q.delete();
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_commit === 1'b1) take(K_COMMIT);
      if (abort === 1'b1)     take(K_ABORT);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic strobe(input int len, input bit exp_commit, input string tag);
    cur_tag = tag;
    if (exp_commit) expect_ev(K_COMMIT, tag);
    step(1);
    ce_n = 1'b0; we_n = 1'b0;
    step(len);
    ce_n = 1'b1; we_n = 1'b1;
    step(8);
    drain(tag);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; cur_tag = "R11";
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    dev_rst_n = 1'b1; vlow = 1'b0; busy = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(6);
    @(negedge clk);
    chk("R11", "wr_commit", wr_commit, 1'b0);
    chk("R11", "abort", abort, 1'b0);
    chk("R11", "op_failed", op_failed, 1'b0);
    chk("R11", "halt", halt, 1'b0);
    chk("R11", "dq_oe", dq_oe, 1'b0);

    // R1: exact minimum width commits once; R2: shorter strobes are rejected
    strobe(MIN_W, 1'b1, "R1");
    strobe(MIN_W - 1, 1'b0, "R2");
    strobe(1, 1'b0, "R2");
    // R12: long strobe yields a single commit
    strobe(20, 1'b1, "R12");

    // R3: output enable low inhibits
    oe_n = 1'b0;
    strobe(8, 1'b0, "R3");
    oe_n = 1'b1;
    step(3);

    // R4: low supply inhibits
    vlow = 1'b1;
    strobe(8, 1'b0, "R4");
    vlow = 1'b0;
    step(3);

    // R8: read gating
    ce_n = 1'b0; oe_n = 1'b0;
    step(4);
    @(negedge clk);
    chk("R8", "dq_oe read", dq_oe, 1'b1);
    step(1);
    we_n = 1'b0;
    step(4);
    @(negedge clk);
    chk("R8", "dq_oe while we_n low", dq_oe, 1'b0);
    step(1);
    we_n = 1'b1;
    step(4);

    // R5: device reset low with engine idle: halt, outputs off, no abort
    cur_tag = "R5";
    dev_rst_n = 1'b0;
    step(4);
    @(negedge clk);
    chk("R5", "halt", halt, 1'b1);
    chk("R5", "dq_oe", dq_oe, 1'b0);
    step(1);
    ce_n = 1'b1; oe_n = 1'b1;
    strobe(8, 1'b0, "R5");
    chk("R6", "op_failed after idle reset", op_failed, 1'b0);

    // R10: release, read comes back
    dev_rst_n = 1'b1;
    ce_n = 1'b0; oe_n = 1'b0;
    step(4);
    @(negedge clk);
    chk("R10", "halt", halt, 1'b0);
    chk("R10", "dq_oe", dq_oe, 1'b1);
    step(1);
    ce_n = 1'b1; oe_n = 1'b1;
    step(4);

    // R6/R7: reset during busy operation
    busy = 1'b1;
    cur_tag = "R6";
    expect_ev(K_ABORT, "R6");
    dev_rst_n = 1'b0;
    step(6);
    drain("R6");
    @(negedge clk);
    chk("R7", "op_failed after abort", op_failed, 1'b1);
    step(1);
    dev_rst_n = 1'b1;
    busy = 1'b0;
    step(4);
    @(negedge clk);
    chk("R7", "op_failed holds", op_failed, 1'b1);
    strobe(MIN_W, 1'b1, "R10");
    @(negedge clk);
    chk("R7", "op_failed cleared by commit", op_failed, 1'b0);

    // R9: reset falls in the qualifying cycle
    busy = 1'b1;
    cur_tag = "R9";
    expect_ev(K_ABORT, "R9");
    step(1);
    ce_n = 1'b0; we_n = 1'b0;
    step(MIN_W - 1);
    dev_rst_n = 1'b0;
    step(3);
    ce_n = 1'b1; we_n = 1'b1;
    step(6);
    drain("R9");
    @(negedge clk);
    chk("R9", "op_failed", op_failed, 1'b1);
    step(1);
    dev_rst_n = 1'b1;
    step(4);

    // R9: reset falls one cycle later: commit, then abort
    expect_ev(K_COMMIT, "R9");
    expect_ev(K_ABORT, "R9");
    step(1);
    ce_n = 1'b0; we_n = 1'b0;
    step(MIN_W);
    dev_rst_n = 1'b0;
    step(3);
    ce_n = 1'b1; we_n = 1'b1;
    step(6);
    drain("R9");
    @(negedge clk);
    chk("R9", "op_failed after late reset", op_failed, 1'b1);
    step(1);
    dev_rst_n = 1'b1;
    busy = 1'b0;
    step(4);
    strobe(MIN_W + 2, 1'b1, "R10");

    summary();
    $finish;
  end
endmodule